// File: doc/BRIEF.md
# GPIO Bank with Latched Pin Interrupts

This block is one bank of general-purpose pins, 12 to 32 of them, set by the `NPINS` parameter. Software reaches it through a word-wide register port with a write strobe, a read strobe and a 3-bit register index. Each pin has its own direction bit. An output pin drives the value held in the output-data register. An input pin is sampled through a two-flop synchronizer, and software reads it back through the input-data register.

Every pin can also act as an interrupt source. A per-pin mode bit chooses edge or level sensing, and a per-pin polarity bit chooses which edge or which level counts. A hit sets a sticky status bit, and the bit stays set until software writes a one to the matching bit of the clear register. Status bits latch whether or not their pin is enabled. The single interrupt request line is a registered OR, over all pins, of status AND enable.

Register indices: 0 output data, 1 input data (read only), 2 direction, 3 interrupt enable, 4 trigger mode, 5 trigger polarity, 6 status (read only), 7 clear (write only, reads 0). Bits at or above `NPINS` read as 0.

Top module: `gpio_irq_bank`

## Requirements
- R1: Reset clears every register, so all pins are inputs (`pin_oe`=0), `pin_out`=0, `irq`=0, and the output-data, direction, enable, mode and polarity registers read 0.
- R2: A write to index 0 or index 2 appears on `pin_out` or `pin_oe` after the next clock edge, where a direction bit of 1 makes the pin an output. These registers read back their stored value, and bits at or above `NPINS` read as 0.
- R3: Index 1 returns each pin sampled through two flops, so a pin change becomes visible two clock edges later.
- R4: With mode bit 1 and polarity bit 1, a 0-to-1 change of the synchronized pin sets that pin's status bit (index 6).
- R5: With mode bit 1 and polarity bit 0, a 1-to-0 change of the synchronized pin sets the status bit, and a 0-to-1 change does not.
- R6: With mode bit 0, the status bit is set while the synchronized pin equals the polarity bit (1 means active high, 0 means active low). The bit stays set after the pin goes inactive again.
- R7: Writing index 7 clears each status bit written as 1 and leaves bits written as 0 alone. Index 7 reads 0, and writes to index 6 have no effect.
- R8: When a detection and a clear hit the same status bit in the same cycle, the bit stays set.
- R9: Status bits latch regardless of the enable register. `irq` equals, one cycle later, the OR over all pins of status AND enable.
- R10: Edge mode senses only one direction. With polarity 1, a falling pin sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rd_data` is 0 when low |
| reg_sel | input | 3 | Register index |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `reg_sel` |
| pin_in | input | NPINS | Pin inputs (asynchronous) |
| pin_out | output | NPINS | Output data to the pads |
| pin_oe | output | NPINS | Per-pin output enable |
| irq | output | 1 | Registered bank interrupt request |

## Verification
The assertions assume that `reg_sel` and the write strobe and data are stable around each rising edge. They also assume `pin_in` changes only between edges, so that one synchronizer value exists per cycle and the clear and detect vectors they observe are the ones the status register actually used. The bench drives every input one nanosecond after the falling edge, which keeps all changes far from the active edge. Pins are held for several cycles in the directed cases, so each edge reaches the detector as a single clean transition.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;

  localparam int REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    RG_DOUT = 3'd0,
    RG_DIN  = 3'd1,
    RG_DIR  = 3'd2,
    RG_IEN  = 3'd3,
    RG_TRIG = 3'd4,
    RG_POL  = 3'd5,
    RG_STAT = 3'd6,
    RG_CLR  = 3'd7
  } reg_idx_e;

  // one pin's hit: edge (mode=1) or level (mode=0), polarity picks direction
  function automatic logic pin_hit(input logic mode, input logic pol,
                                   input logic cur, input logic prev);
    if (mode) return pol ? (cur & ~prev) : (~cur & prev);
    else      return (cur == pol);
  endfunction

  // sticky status update; a fresh hit beats a clear
  function automatic logic sticky_next(input logic old, input logic hit,
                                       input logic clr);
    return hit | (old & ~clr);
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
`timescale 1ns/1ps
module gpio_pin_sync #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] cur,
  output logic [NPINS-1:0] prev
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic meta_q, sync_q, last_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        last_q <= 1'b0;
      end else begin
        meta_q <= pin_in[i];
        sync_q <= meta_q;
        last_q <= sync_q;
      end
    end
    assign cur[i]  = sync_q;
    assign prev[i] = last_q;
  end

endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] mode,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] cur,
  input  logic [NPINS-1:0] prev,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] hit,
  output logic [NPINS-1:0] status
);

  for (genvar i = 0; i < NPINS; i++) begin : g_det
    logic st_q;
    assign hit[i] = pin_hit(mode[i], pol[i], cur[i], prev[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= 1'b0;
      else        st_q <= sticky_next(st_q, hit[i], clr[i]);
    end
    assign status[i] = st_q;
  end

endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DW    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [REG_IDX_W-1:0] reg_sel,
  input  logic [DW-1:0]        wr_data,
  input  logic [NPINS-1:0]     din,
  input  logic [NPINS-1:0]     status,
  output logic [DW-1:0]        rd_data,
  output logic [NPINS-1:0]     dout_q,
  output logic [NPINS-1:0]     dir_q,
  output logic [NPINS-1:0]     ien_q,
  output logic [NPINS-1:0]     trig_q,
  output logic [NPINS-1:0]     pol_q,
  output logic [NPINS-1:0]     clr_w
);

  reg_idx_e         sel;
  logic [NPINS-1:0] wbits;

  assign sel   = reg_idx_e'(reg_sel);
  assign wbits = wr_data[NPINS-1:0];
  assign clr_w = (wr_en && sel == RG_CLR) ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
      trig_q <= '0;
      pol_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        RG_DOUT: dout_q <= wbits;
        RG_DIR:  dir_q  <= wbits;
        RG_IEN:  ien_q  <= wbits;
        RG_TRIG: trig_q <= wbits;
        RG_POL:  pol_q  <= wbits;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (sel)
        RG_DOUT: rd_data[NPINS-1:0] = dout_q;
        RG_DIN:  rd_data[NPINS-1:0] = din;
        RG_DIR:  rd_data[NPINS-1:0] = dir_q;
        RG_IEN:  rd_data[NPINS-1:0] = ien_q;
        RG_TRIG: rd_data[NPINS-1:0] = trig_q;
        RG_POL:  rd_data[NPINS-1:0] = pol_q;
        RG_STAT: rd_data[NPINS-1:0] = status;
        default: rd_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DW    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [REG_IDX_W-1:0] reg_sel,
  input  logic [DW-1:0]        wr_data,
  output logic [DW-1:0]        rd_data,
  input  logic [NPINS-1:0]     pin_in,
  output logic [NPINS-1:0]     pin_out,
  output logic [NPINS-1:0]     pin_oe,
  output logic                 irq
);

  if (NPINS < 12 || NPINS > DW) begin : g_bad_cfg
    $error("gpio_irq_bank: NPINS must lie in 12..DW");
  end

  logic [NPINS-1:0] cur_w, prev_w, det_w, stat_q;
  logic [NPINS-1:0] ien_q, trig_q, pol_q, clr_w;

  gpio_pin_sync #(.NPINS(NPINS)) sync_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cur(cur_w), .prev(prev_w)
  );

  gpio_irq_detect #(.NPINS(NPINS)) det_i (
    .clk(clk), .rst_n(rst_n), .mode(trig_q), .pol(pol_q), .cur(cur_w),
    .prev(prev_w), .clr(clr_w), .hit(det_w), .status(stat_q)
  );

  gpio_bank_regs #(.NPINS(NPINS), .DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .reg_sel(reg_sel), .wr_data(wr_data), .din(cur_w), .status(stat_q),
    .rd_data(rd_data), .dout_q(pin_out), .dir_q(pin_oe), .ien_q(ien_q),
    .trig_q(trig_q), .pol_q(pol_q), .clr_w(clr_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(stat_q & ien_q);
  end

endmodule

// File: rtl/gpio_irq_bank_chk.sv
`timescale 1ns/1ps
module gpio_irq_bank_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] stat_q,
  input logic [NPINS-1:0] ien_q,
  input logic [NPINS-1:0] det_w,
  input logic [NPINS-1:0] clr_w
);

  // R1: a cycle spent in reset leaves all pins as inputs and no request
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (irq == 1'b0 && pin_oe == '0));

  // R9: request follows enabled status one cycle later
  a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|(stat_q & ien_q)));

  // R8: detection beats a same-cycle clear
  a_r8_detect_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (det_w & clr_w) != '0 |=>
      (stat_q & $past(det_w & clr_w)) == $past(det_w & clr_w));

  // R6: set bits not cleared stay set
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_q & $past(stat_q & ~clr_w)) == $past(stat_q & ~clr_w));

  // R7: cleared bits without a new hit drop
  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_q & $past(clr_w & ~det_w)) == '0);

  // R4: a status bit only rises from a detection
  a_r4_rise_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_q & ~$past(stat_q) & ~$past(det_w)) == '0);

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .pin_oe(pin_oe), .stat_q(stat_q),
  .ien_q(ien_q), .det_w(det_w), .clr_w(clr_w)
);

// File: tb/gpio_irq_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb_top;

  localparam int NP = 20;
  localparam logic [NP-1:0] ALL = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]    reg_sel = '0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq;

  int nvec = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_irq_bank #(.NPINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // ---------------- reference model built from the requirements
  logic [NP-1:0] m_s1, m_s2, m_last, m_dout, m_dir, m_ien, m_mode, m_pol, m_stat;
  logic          m_irq;

  function automatic logic [NP-1:0] b_hits(input logic [NP-1:0] md, pl, c, p);
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++) begin
      case ({md[i], pl[i]})
        2'b11:   r[i] = (p[i] == 1'b0) && (c[i] == 1'b1);
        2'b10:   r[i] = (p[i] == 1'b1) && (c[i] == 1'b0);
        2'b01:   r[i] = c[i];
        default: r[i] = !c[i];
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] b_read(input logic [2:0] s);
    logic [NP-1:0] v;
    case (s)
      3'd0: v = m_dout;  3'd1: v = m_s2;   3'd2: v = m_dir;  3'd3: v = m_ien;
      3'd4: v = m_mode;  3'd5: v = m_pol;  3'd6: v = m_stat; default: v = '0;
    endcase
    return {{(32-NP){1'b0}}, v};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_last <= '0; m_dout <= '0; m_dir <= '0;
      m_ien <= '0; m_mode <= '0; m_pol <= '0; m_stat <= '0; m_irq <= 1'b0;
    end else begin
      m_s1 <= pin_in; m_s2 <= m_s1; m_last <= m_s2;
      m_stat <= b_hits(m_mode, m_pol, m_s2, m_last) |
                (m_stat & ~((wr_en && reg_sel == 3'd7) ? wr_data[NP-1:0] : '0));
      m_irq <= |(m_stat & m_ien);
      if (wr_en) begin
        case (reg_sel)
          3'd0: m_dout <= wr_data[NP-1:0];
          3'd2: m_dir  <= wr_data[NP-1:0];
          3'd3: m_ien  <= wr_data[NP-1:0];
          3'd4: m_mode <= wr_data[NP-1:0];
          3'd5: m_pol  <= wr_data[NP-1:0];
          default: ;
        endcase
      end
    end
  end

  // ---------------- checking helpers
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 pin_out vs model", {{(32-NP){1'b0}}, pin_out}, {{(32-NP){1'b0}}, m_dout});
      chk("R2 pin_oe vs model",  {{(32-NP){1'b0}}, pin_oe},  {{(32-NP){1'b0}}, m_dir});
      chk("R9 irq vs model", {31'd0, irq}, {31'd0, m_irq});
    end
  end

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; reg_sel = s; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_now(input string tag, input logic [2:0] s, input logic [31:0] exp);
    rd_en = 1'b1; reg_sel = s; #1;
    chk(tag, rd_data, exp);
    chk({tag, " model"}, rd_data, b_read(s));
    rd_en = 1'b0;
  endtask

  task automatic pins(input logic [NP-1:0] v);
    @(negedge clk); #1; pin_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // ---------------- watchdog
  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      nvec++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  // ---------------- stimulus
  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 pin_oe after reset", {{(32-NP){1'b0}}, pin_oe}, 32'd0);
    chk("R1 pin_out after reset", {{(32-NP){1'b0}}, pin_out}, 32'd0);
    rd_now("R1 dout", 3'd0, 32'd0);
    rd_now("R1 dir",  3'd2, 32'd0);
    rd_now("R1 ien",  3'd3, 32'd0);
    rd_now("R1 mode", 3'd4, 32'd0);
    rd_now("R1 pol",  3'd5, 32'd0);

    // R2 output data and direction, upper bits read 0
    wr(3'd0, 32'hFFFF_FFFF);
    chk("R2 pin_out all", {{(32-NP){1'b0}}, pin_out}, 32'h000F_FFFF);
    rd_now("R2 dout readback", 3'd0, 32'h000F_FFFF);
    wr(3'd2, 32'h0000_0ABC);
    chk("R2 pin_oe pattern", {{(32-NP){1'b0}}, pin_oe}, 32'h0000_0ABC);
    rd_now("R2 dir readback", 3'd2, 32'h0000_0ABC);

    // R3 input through two flops
    pins(20'hA5A5A);
    idle(3);
    rd_now("R3 din", 3'd1, 32'h000A_5A5A);
    pins('0);
    idle(3);

    // R4 rising edge, then R10 falling ignored
    wr(3'd5, ALL);
    wr(3'd4, ALL);
    wr(3'd7, ALL);
    rd_now("R4 status clean", 3'd6, 32'd0);
    pins(20'h00001);
    idle(4);
    rd_now("R4 rising sets bit0", 3'd6, 32'h1);
    wr(3'd7, 32'h1);
    rd_now("R7 clear bit0", 3'd6, 32'h0);
    pins('0);
    idle(4);
    rd_now("R10 falling ignored", 3'd6, 32'h0);

    // R5 falling edge mode
    wr(3'd5, 32'h0);
    wr(3'd7, ALL);
    pins(20'h00002);
    idle(4);
    rd_now("R5 rising ignored", 3'd6, 32'h0);
    pins('0);
    idle(4);
    rd_now("R5 falling sets bit1", 3'd6, 32'h2);

    // R6 level high, sticky
    wr(3'd5, ALL);
    wr(3'd4, 32'h0);
    wr(3'd7, ALL);
    pins(20'h00004);
    idle(4);
    pins('0);
    idle(4);
    rd_now("R6 level sticky", 3'd6, 32'h4);
    pins(20'h00008);
    idle(4);
    pins('0);
    idle(4);
    rd_now("R6 second level", 3'd6, 32'hC);

    // R7 partial clear, clear reads 0, status write ignored
    wr(3'd7, 32'h4);
    rd_now("R7 partial clear", 3'd6, 32'h8);
    rd_now("R7 clear reads 0", 3'd7, 32'h0);
    wr(3'd6, ALL);
    rd_now("R7 status write ignored", 3'd6, 32'h8);

    // R9 latch without enable, then enable
    chk("R9 no irq when disabled", {31'd0, irq}, 32'd0);
    wr(3'd3, 32'h8);
    idle(2);
    chk("R9 irq raised", {31'd0, irq}, 32'd1);
    wr(3'd7, 32'h8);
    idle(2);
    chk("R9 irq dropped", {31'd0, irq}, 32'd0);

    // R8 detect wins over clear on a held level
    pins(20'h00010);
    idle(4);
    wr(3'd7, 32'h10);
    rd_now("R8 detect beats clear", 3'd6, 32'h10);
    pins('0);
    idle(3);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      reg_sel = 3'($urandom_range(0, 7));
      wr_en   = ($urandom_range(0, 3) == 0);
      wr_data = $urandom();
      rd_en   = 1'b1;
      if ($urandom_range(0, 2) == 0) pin_in = NP'($urandom());
      #1;
      chk("R2/R3/R4/R6 random read", rd_data, b_read(reg_sel));
    end
    @(negedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
    idle(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule